// File: doc/BRIEF.md
# Audio Test Tone and Sweep Sequencer

This block produces a fully known audio stimulus for judging a single-bit audio modulator by ear or by measurement. From the system clock it derives a fixed audio sample rate (100 MHz and 32 kHz by default, one sample every 3125 clocks). Each sample is presented as a signed 16-bit word together with a one-clock valid strobe. A downstream modulator takes the word on that strobe.

The sequence starts when the single test switch goes from low to high. It runs silence, then a steady tone (440 Hz for two seconds), then a rising sweep (110 Hz to about 20.5 kHz over three seconds), then silence again, and then returns to idle. The sweep runs past half the sample rate on purpose, so aliasing becomes audible. Frequency comes from a phase accumulator. Its top bits address a quarter-wave sine table that is computed while the design is elaborated. The block also holds the amplifier gain pin at its high-gain level and the active-low shutdown pin released.

The sequencer has five states. IDLE moves to LEAD on a switch rising edge. LEAD moves to TONE, TONE moves to SWEEP, SWEEP moves to TAIL, and TAIL moves back to IDLE. Each of these moves is taken on the strobe that ends the segment's programmed sample count.

Top module: `audseq_gen`

## Requirements
- R1: `sample_valid` is high for exactly one clock in every `CLKS_PER_SAMPLE` clocks, in every state including idle.
- R2: After reset the block is idle, `sample_out` is 0, and every strobe carries 0 until a start edge is seen.
- R3: A low-to-high change of `start_sw` while idle starts the sequence. If the switch rises just after a strobe (and `CLKS_PER_SAMPLE` is at least 6), exactly `LEAD_SAMPLES` zero samples follow before the first tone sample.
- R4: The tone segment has `TONE_SAMPLES` samples. Its sample n is sine(n * `TONE_INC` mod 2^32).
- R5: sine(phase) is round(AMP * sin(2*pi*(p + 0.5)/1024)), where p = phase[31:22] and AMP = 2^(SAMPLE_W-1) - 1. The result is within 1 LSB, and it is never zero.
- R6: The sweep segment has `SWEEP_SAMPLES` samples. Its sample k is sine(P_k), where P_0 = 0, P_(k+1) = P_k + I_k, and I_k = `SWEEP_START_INC` + k * `SWEEP_STEP`, all mod 2^32.
- R7: The phase accumulator returns to zero at the start of each segment, so the first tone sample and the first sweep sample both equal sine(0), which is 101 at the default width.
- R8: The trailing segment has `TAIL_SAMPLES` samples, all exactly 0. After it the block is idle, and later samples stay 0.
- R9: Switch edges while the sequence is running have no effect on the samples. A fresh rising edge after the block returns to idle starts a new sequence.
- R10: `amp_gain` is 1 and `amp_shutdown_n` is 1 on every clock after reset.
- R11: The state only moves along IDLE, LEAD, TONE, SWEEP, TAIL, IDLE. Every move except the one out of IDLE happens on a sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_sw | input | 1 | Test switch; a rising edge starts the sequence |
| sample_out | output | SAMPLE_W | Signed audio sample, held between strobes |
| sample_valid | output | 1 | One-clock strobe marking a new sample |
| amp_gain | output | 1 | Amplifier gain select, held high |
| amp_shutdown_n | output | 1 | Amplifier shutdown, active low, held released |

## Verification
The bench goes after the segment boundaries. If the sample counter were off by one, the design would emit one zero too many or too few around the tone. If the phase clear at a boundary were missing, the first sweep sample would carry on from the tone's phase instead of equalling sine(0). The sweep runs its increment past half the phase range, so a design whose ramp stepped on the wrong tick, or truncated the increment, would drift away from the expected aliased samples. The bench also toggles the switch in the middle of the tone and in the middle of the sweep; a design that restarted on that edge would break the expected stream at once.

// File: rtl/audseq_pkg.sv
package audseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TONE,
        ST_SWEEP,
        ST_TAIL
    } seq_state_t;

    // Legal successor of each sequencer state
    function automatic seq_state_t seq_succ(input seq_state_t s);
        case (s)
            ST_IDLE:  return ST_LEAD;
            ST_LEAD:  return ST_TONE;
            ST_TONE:  return ST_SWEEP;
            ST_SWEEP: return ST_TAIL;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/audseq_tick.sv
module audseq_tick #(
    parameter int CLKS_PER_SAMPLE = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (CLKS_PER_SAMPLE > 2) ? $clog2(CLKS_PER_SAMPLE) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CLKS_PER_SAMPLE - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == DIV_END);

    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/audseq_nco.sv
module audseq_nco #(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 10,
    parameter logic [PHASE_W-1:0] RAMP_STEP = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [PHASE_W-1:0] load_inc,
    input  logic               step,
    input  logic               ramp,
    output logic [IDX_W-1:0]   phase_idx
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] inc_q;

    assign phase_idx = phase_q[PHASE_W-1 -: IDX_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            inc_q   <= '0;
        end else if (clr) begin
            phase_q <= '0;
            inc_q   <= load_inc;
        end else if (step) begin
            phase_q <= phase_q + inc_q;
            if (ramp) inc_q <= inc_q + RAMP_STEP;
        end
    end
endmodule

// File: rtl/audseq_sine.sv
module audseq_sine #(
    parameter int SAMPLE_W   = 16,
    parameter int TABLE_BITS = 8
) (
    input  logic [TABLE_BITS+1:0]       phase_idx,
    output logic signed [SAMPLE_W-1:0]  sine
);
    localparam int    QN  = 1 << TABLE_BITS;
    localparam real   PI  = 3.14159265358979323846;
    localparam real   AMP = real'((1 << (SAMPLE_W - 1)) - 1);

    // Quarter-wave magnitude at the centre of slot k, Taylor series to x^15
    function automatic int quarter_mag(input int k);
        real x, term, acc;
        x    = (real'(k) + 0.5) * PI / (2.0 * real'(QN));
        term = x;
        acc  = x;
        for (int n = 1; n < 8; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(AMP * acc + 0.5);
    endfunction

    logic [SAMPLE_W-2:0] qtab [QN];

    for (genvar g = 0; g < QN; g++) begin : g_qtab
        assign qtab[g] = (SAMPLE_W-1)'(quarter_mag(g));
    end

    logic [1:0]              quad;
    logic [TABLE_BITS-1:0]   addr;
    logic signed [SAMPLE_W-1:0] mag;

    always_comb begin
        quad = phase_idx[TABLE_BITS+1:TABLE_BITS];
        addr = quad[0] ? ~phase_idx[TABLE_BITS-1:0] : phase_idx[TABLE_BITS-1:0];
        mag  = signed'({1'b0, qtab[addr]});
        sine = quad[1] ? -mag : mag;
    end
endmodule

// File: rtl/audseq_gen.sv
module audseq_gen
    import audseq_pkg::*;
#(
    parameter int SAMPLE_W        = 16,
    parameter int PHASE_W         = 32,
    parameter int TABLE_BITS      = 8,
    parameter int CLKS_PER_SAMPLE = 3125,
    parameter int LEAD_SAMPLES    = 16000,
    parameter int TONE_SAMPLES    = 64000,
    parameter int SWEEP_SAMPLES   = 96000,
    parameter int TAIL_SAMPLES    = 16000,
    parameter logic [PHASE_W-1:0] TONE_INC        = 32'd59055800,
    parameter logic [PHASE_W-1:0] SWEEP_START_INC = 32'd14763950,
    parameter logic [PHASE_W-1:0] SWEEP_STEP      = 32'd28508
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_sw,
    output logic signed [SAMPLE_W-1:0] sample_out,
    output logic                       sample_valid,
    output logic                       amp_gain,
    output logic                       amp_shutdown_n
);
    localparam int IDX_W  = TABLE_BITS + 2;
    localparam int MAX_LT = (LEAD_SAMPLES > TONE_SAMPLES) ? LEAD_SAMPLES : TONE_SAMPLES;
    localparam int MAX_ST = (SWEEP_SAMPLES > TAIL_SAMPLES) ? SWEEP_SAMPLES : TAIL_SAMPLES;
    localparam int MAXLEN = (MAX_LT > MAX_ST) ? MAX_LT : MAX_ST;
    localparam int CNT_W  = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] seg_end;
    logic             tick;
    logic             seg_last;
    logic             sw_meta, sw_sync, sw_prev;
    logic             start_edge;
    logic             in_sine;
    logic             nco_clr, nco_step;
    logic [PHASE_W-1:0] nco_load;
    logic [IDX_W-1:0]   phase_idx;
    logic signed [SAMPLE_W-1:0] sine_val;

    audseq_tick #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    audseq_nco #(.PHASE_W(PHASE_W), .IDX_W(IDX_W), .RAMP_STEP(SWEEP_STEP)) u_nco (
        .clk(clk), .rst_n(rst_n), .clr(nco_clr), .load_inc(nco_load),
        .step(nco_step), .ramp(state == ST_SWEEP), .phase_idx(phase_idx)
    );

    audseq_sine #(.SAMPLE_W(SAMPLE_W), .TABLE_BITS(TABLE_BITS)) u_sine (
        .phase_idx(phase_idx), .sine(sine_val)
    );

    // Switch synchroniser and edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_meta <= 1'b0;
            sw_sync <= 1'b0;
            sw_prev <= 1'b0;
        end else begin
            sw_meta <= start_sw;
            sw_sync <= sw_meta;
            sw_prev <= sw_sync;
        end
    end
    assign start_edge = sw_sync & ~sw_prev;

    // Segment length and transition decode
    always_comb begin
        seg_end  = '0;
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_edge) state_nx = ST_LEAD;
            ST_LEAD:  seg_end = CNT_W'(LEAD_SAMPLES - 1);
            ST_TONE:  seg_end = CNT_W'(TONE_SAMPLES - 1);
            ST_SWEEP: seg_end = CNT_W'(SWEEP_SAMPLES - 1);
            ST_TAIL:  seg_end = CNT_W'(TAIL_SAMPLES - 1);
        endcase
        seg_last = tick && (state != ST_IDLE) && (cnt_q == seg_end);
        if (seg_last) state_nx = seq_succ(state);
    end

    assign in_sine  = (state == ST_TONE) || (state == ST_SWEEP);
    assign nco_clr  = seg_last;
    assign nco_load = (state == ST_LEAD) ? TONE_INC : SWEEP_START_INC;
    assign nco_step = tick && in_sine && !seg_last;

    // State register and sample counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state)              cnt_q <= '0;
            else if (tick && state != ST_IDLE)  cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= tick;
            if (tick) sample_out <= in_sine ? sine_val : '0;
        end
    end

    assign amp_gain       = 1'b1;
    assign amp_shutdown_n = 1'b1;
endmodule

// File: rtl/audseq_gen_chk.sv
module audseq_gen_chk
    import audseq_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input seq_state_t                 state,
    input logic                       tick,
    input logic                       sample_valid,
    input logic signed [SAMPLE_W-1:0] sample_out
);
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    assert_silence_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && ($past(state) == ST_IDLE || $past(state) == ST_LEAD ||
                          $past(state) == ST_TAIL)) |-> (sample_out == '0));

    assert_sine_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && ($past(state) == ST_TONE || $past(state) == ST_SWEEP))
            |-> (sample_out != '0));

    assert_state_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (state == seq_succ($past(state))));

    assert_move_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state) && $past(state) != ST_IDLE) |-> $past(tick));
endmodule

bind audseq_gen audseq_gen_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .tick(tick),
    .sample_valid(sample_valid), .sample_out(sample_out)
);

// File: tb/audseq_gen_bench.sv
module audseq_gen_bench;
    localparam int CPS   = 8;
    localparam int LEAD  = 5;
    localparam int TONE  = 40;
    localparam int SWEEP = 60;
    localparam int TAIL  = 5;
    localparam logic [31:0] TINC   = 32'h0B37_1C5D;
    localparam logic [31:0] SSTART = 32'h0100_0000;
    localparam logic [31:0] SSTEP  = 32'h0240_0000;
    localparam real PI = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_sw = 1'b0;
    logic signed [15:0] sample_out;
    logic sample_valid, amp_gain, amp_shutdown_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    audseq_gen #(
        .CLKS_PER_SAMPLE(CPS), .LEAD_SAMPLES(LEAD), .TONE_SAMPLES(TONE),
        .SWEEP_SAMPLES(SWEEP), .TAIL_SAMPLES(TAIL), .TONE_INC(TINC),
        .SWEEP_START_INC(SSTART), .SWEEP_STEP(SSTEP)
    ) u_audseq_gen (
        .clk(clk), .rst_n(rst_n), .start_sw(start_sw), .sample_out(sample_out),
        .sample_valid(sample_valid), .amp_gain(amp_gain), .amp_shutdown_n(amp_shutdown_n)
    );

    always #10 clk = ~clk;

    function automatic int exp_sine(input logic [31:0] ph);
        real v;
        v = 32767.0 * $sin(2.0 * PI * (real'(ph[31:22]) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!sample_valid);
    endtask

    // R1: strobe spacing monitor
    int since = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid) begin
                if (since >= 0) chk(since + 1 == CPS, "R1 strobe spacing", since + 1, CPS);
                since = 0;
            end else if (since >= 0) since++;
        end
    end

    // R10: amplifier pins on every clock
    always @(negedge clk) begin
        if (rst_n && !(amp_gain == 1'b1 && amp_shutdown_n == 1'b1))
            chk(1'b0, "R10 amp pins", {amp_gain, amp_shutdown_n}, 3);
    end

    // One full sequence; retrig_pos < 0 disables the mid-run switch toggle
    task automatic do_run(input int retrig_pos);
        logic [31:0] ph, inc;
        int total, e, a;
        total = LEAD + TONE + SWEEP + TAIL + 3;
        ph = '0;
        inc = SSTART;
        wait_strobe();
        start_sw = 1'b1;
        for (int i = 0; i < total; i++) begin
            wait_strobe();
            a = int'(sample_out);
            if (i == retrig_pos)     start_sw = 1'b0;
            if (i == retrig_pos + 1) start_sw = 1'b1;
            if (i < LEAD) begin
                chk(a == 0, "R3 lead silence", a, 0);
            end else if (i < LEAD + TONE) begin
                e = exp_sine(TINC * 32'(i - LEAD));
                if (i == LEAD) chk(a == 101, "R7 tone phase reset", a, 101);
                chk(a - e <= 1 && e - a <= 1, "R4 R5 tone sample", a, e);
            end else if (i < LEAD + TONE + SWEEP) begin
                if (i == LEAD + TONE) begin
                    ph = '0;
                    inc = SSTART;
                    chk(a == 101, "R7 sweep phase reset", a, 101);
                end
                e = exp_sine(ph);
                chk(a - e <= 1 && e - a <= 1, "R6 sweep sample", a, e);
                ph  = ph + inc;
                inc = inc + SSTEP;
            end else begin
                chk(a == 0, (retrig_pos >= 0) ? "R9 R8 tail idle" : "R8 tail idle", a, 0);
            end
        end
        start_sw = 1'b0;
    endtask

    initial begin
        int gap;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        chk(sample_out == 0, "R2 reset sample", int'(sample_out), 0);
        chk(sample_valid == 1'b0, "R2 reset strobe", int'(sample_valid), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_strobe();
            chk(sample_out == 0, "R2 idle silence", int'(sample_out), 0);
        end
        // plain run
        do_run(-1);
        // retrigger inside tone, then inside sweep (R9), random positions
        for (int r = 0; r < 2; r++) begin
            gap = int'($urandom_range(3, 0));
            for (int k = 0; k < gap; k++) begin
                wait_strobe();
                chk(sample_out == 0, "R9 idle between runs", int'(sample_out), 0);
            end
            if (r == 0) do_run(LEAD + 2 + int'($urandom_range(TONE - 6, 0)));
            else        do_run(LEAD + TONE + 2 + int'($urandom_range(SWEEP - 6, 0)));
        end
        chk(amp_gain == 1'b1 && amp_shutdown_n == 1'b1, "R10 amp pins end",
            {amp_gain, amp_shutdown_n}, 3);
        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end
endmodule